// File: doc/BRIEF.md
# Quad-data-rate burst-of-four static memory

This block is a synthesizable behavioural model of a static memory with two independent double-data-rate ports. One port only takes write data and the other only drives read data, so a read burst and a write burst can run in the same cycles. Both ports share one address bus. The read address is sampled on the rising edge of the input clock `clk_k`. The write address is sampled on the rising edge of its complement `clk_kn`. Each address names a line of four 18-bit words, and a line always moves as a burst of four beats, one beat on every rising edge of a clock pair.

Write beats are gathered in pairs in the `clk_k` domain, and the full line is stored once all four beats have arrived. Each beat carries its own pair of active-low lane selects. Read lines are fetched from the array and split into two pairs. These pairs are then sent out one word per edge, through registers clocked by the output pair `clk_c`/`clk_cn`. A valid flag marks every beat. The number of lines is set by `ADDR_W`. The default is 64 lines, and `ADDR_W = 17` gives the full-size array.

Three small state machines run the block. The read port has RD_READY and RD_SECOND: an accepted read moves it from RD_READY to RD_SECOND, and it always returns to RD_READY on the next cycle. The write port has WR_READY and WR_UPPER: a captured write request moves it to WR_UPPER, and the line is committed as it returns to WR_READY. The output sequencer has OUT_IDLE and OUT_UPPER: a line fetch moves it to OUT_UPPER, which sends the second pair and then returns to OUT_IDLE.

Top module: `qdr_burst_sram`

## Requirements
- R1: From reset, and until the first read beat is due, `q_valid` stays low.
- R2: A read is accepted on a `clk_k` rising edge with `rps_n` low while the read port is idle. Its words 0, 1, 2, 3 are presented on `q` with `q_valid` high in the half-cycles that follow the 8th, 9th, 10th and 11th clock-pair edges after the request edge. The edges alternate `clk_c`, `clk_cn`, `clk_c`, `clk_cn`.
- R3: A write is requested by `wps_n` low on a `clk_kn` rising edge, and `addr` on that edge is the line. Word 0 is the `d` sampled on the `clk_k` edge before it, word 1 is sampled on that same `clk_kn` edge, word 2 on the next `clk_k` edge and word 3 on the next `clk_kn` edge.
- R4: During a write beat, `bws_n[0]` low stores `d[8:0]` and `bws_n[1]` low stores `d[17:9]`. A lane whose select is high keeps its previous contents.
- R5: Each port accepts at most one request every two `clk_k` cycles. A request on a port in the cycle after that port accepted one is ignored and changes neither memory nor output. Requests every second cycle give gapless beats.
- R6: A read and a write to the same line in one cycle (read on `clk_k`, write on the next `clk_kn`) return the new data in the enabled lanes. A write accepted in the following cycle does not affect that read.
- R7: `q_valid` is low in every half-cycle that carries no read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock; read requests and even write beats sampled on its rise |
| clk_kn | input | 1 | Complement input clock; write requests and odd write beats sampled on its rise |
| clk_c | input | 1 | Output clock for read words 0 and 2 |
| clk_cn | input | 1 | Complement output clock for read words 1 and 3 |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared line address (read on `clk_k`, write on `clk_kn`) |
| rps_n | input | 1 | Active-low read port select |
| wps_n | input | 1 | Active-low write port select |
| bws_n | input | 2 | Active-low lane selects for the current write beat |
| d | input | 18 | Write data beat |
| q | output | 18 | Read data beat |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
The hardest case to reach from the ports is a read and a write to the same line inside one cycle pair. It must be combined with lane masks that differ from beat to beat and with a refused request arriving on the busy port. A directed first phase writes every line while reading the same line in the same cycle, and puts ignored requests in every gap. A second phase reads back the whole array without gaps, which exposes any refused write that leaked into memory. A random phase then crowds reads and writes onto eight lines with random lane masks. Expected beats come from a bench model that replays the acceptance rules, so the model reaches the new-data and old-data overlap cases often.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BURST       = 4;
    localparam int FETCH_DELAY = 3;

    typedef enum logic {RD_READY, RD_SECOND} rd_state_e;
    typedef enum logic {WR_READY, WR_UPPER} wr_state_e;
    typedef enum logic {OUT_IDLE, OUT_UPPER} out_state_e;
endpackage

// File: rtl/qdr_wr_port.sv
module qdr_wr_port
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic                      clk_k,
    input  logic                      clk_kn,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wps_n,
    input  logic [LANES-1:0]          bws_n,
    input  logic [WORD_W-1:0]         d,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [BURST*WORD_W-1:0]   wr_data,
    output logic [BURST*LANES-1:0]    wr_sel_n
);
    localparam int PAIR_W = 2 * WORD_W;
    localparam int PAIR_S = 2 * LANES;

    logic [WORD_W-1:0] even_d, odd_d;
    logic [LANES-1:0]  even_sel, odd_sel;
    logic              req_seen;
    logic [ADDR_W-1:0] req_addr;
    logic [PAIR_W-1:0] low_d;
    logic [PAIR_S-1:0] low_sel;
    logic [ADDR_W-1:0] line_addr;
    wr_state_e         st, st_nx;

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            even_d   <= '0;
            even_sel <= '1;
        end else begin
            even_d   <= d;
            even_sel <= bws_n;
        end
    end

    always_ff @(posedge clk_kn or negedge rst_n) begin
        if (!rst_n) begin
            odd_d    <= '0;
            odd_sel  <= '1;
            req_seen <= 1'b0;
            req_addr <= '0;
        end else begin
            odd_d    <= d;
            odd_sel  <= bws_n;
            req_seen <= !wps_n;
            req_addr <= addr;
        end
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) st <= WR_READY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WR_READY: if (req_seen) st_nx = WR_UPPER;
            WR_UPPER: st_nx = WR_READY;
        endcase
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            low_d     <= '0;
            low_sel   <= '1;
            line_addr <= '0;
        end else if (st == WR_READY && req_seen) begin
            low_d     <= {odd_d, even_d};
            low_sel   <= {odd_sel, even_sel};
            line_addr <= req_addr;
        end
    end

    assign wr_en    = (st == WR_UPPER);
    assign wr_addr  = line_addr;
    assign wr_data  = {odd_d, even_d, low_d};
    assign wr_sel_n = {odd_sel, even_sel, low_sel};

    // R5: two commits never fall on adjacent cycles
    p_commit_spacing_r5: assert property (@(posedge clk_k) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R3: every commit follows a write request seen on clk_kn
    p_commit_has_request_r3: assert property (@(posedge clk_k) disable iff (!rst_n)
        wr_en |-> $past(req_seen));
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_k,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rps_n,
    output logic              fetch_v,
    output logic [ADDR_W-1:0] fetch_addr
);
    rd_state_e st, st_nx;
    logic      take;
    logic [FETCH_DELAY-1:0]             pipe_v;
    logic [FETCH_DELAY-1:0][ADDR_W-1:0] pipe_a;

    assign take = (st == RD_READY) && !rps_n;

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) st <= RD_READY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_READY:  if (!rps_n) st_nx = RD_SECOND;
            RD_SECOND: st_nx = RD_READY;
        endcase
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            pipe_v <= '0;
            pipe_a <= '0;
        end else begin
            pipe_v <= {pipe_v[FETCH_DELAY-2:0], take};
            pipe_a <= {pipe_a[FETCH_DELAY-2:0], addr};
        end
    end

    assign fetch_v    = pipe_v[FETCH_DELAY-1];
    assign fetch_addr = pipe_a[FETCH_DELAY-1];

    // R5: a read is never accepted in two adjacent cycles
    p_read_spacing_r5: assert property (@(posedge clk_k) disable iff (!rst_n)
        take |=> !take);
    // R2: a fetch happens a fixed three cycles after acceptance
    p_fetch_delay_r2: assert property (@(posedge clk_k) disable iff (!rst_n)
        fetch_v |-> $past(take, FETCH_DELAY));
endmodule

// File: rtl/qdr_array.sv
module qdr_array
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic                    clk_k,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BURST*WORD_W-1:0] wr_data,
    input  logic [BURST*LANES-1:0]  wr_sel_n,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BURST*WORD_W-1:0] rd_line
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = WORD_W / LANES;
    localparam int SLICES = BURST * LANES;

    logic [BURST*WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_k) begin
        if (wr_en) begin
            for (int p = 0; p < SLICES; p++) begin
                if (!wr_sel_n[p])
                    mem[wr_addr][p*LANE_W +: LANE_W] <= wr_data[p*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_line = mem[rd_addr];

    // R3: a commit always targets a defined line
    p_commit_addr_known_r3: assert property (@(posedge clk_k)
        wr_en |-> !$isunknown(wr_addr));
endmodule

// File: rtl/qdr_out_ddr.sv
module qdr_out_ddr
    import qdr_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic                    clk_k,
    input  logic                    clk_c,
    input  logic                    clk_cn,
    input  logic                    rst_n,
    input  logic                    fetch_v,
    input  logic [BURST*WORD_W-1:0] line,
    output logic [WORD_W-1:0]       q,
    output logic                    q_valid
);
    localparam int PAIR_W = 2 * WORD_W;

    out_state_e        st, st_nx;
    logic [PAIR_W-1:0] upper_h;
    logic [PAIR_W-1:0] pair_d;
    logic              pair_v;
    logic [WORD_W-1:0] q_c, q_cn, late_w;
    logic              v_c, v_cn;

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) st <= OUT_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            OUT_IDLE:  if (fetch_v) st_nx = OUT_UPPER;
            OUT_UPPER: st_nx = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            pair_d  <= '0;
            pair_v  <= 1'b0;
            upper_h <= '0;
        end else if (fetch_v) begin
            pair_d  <= line[PAIR_W-1:0];
            upper_h <= line[2*PAIR_W-1:PAIR_W];
            pair_v  <= 1'b1;
        end else if (st == OUT_UPPER) begin
            pair_d  <= upper_h;
            pair_v  <= 1'b1;
        end else begin
            pair_v  <= 1'b0;
        end
    end

    always_ff @(posedge clk_c or negedge rst_n) begin
        if (!rst_n) begin
            q_c    <= '0;
            late_w <= '0;
            v_c    <= 1'b0;
        end else begin
            q_c    <= pair_d[WORD_W-1:0];
            late_w <= pair_d[PAIR_W-1:WORD_W];
            v_c    <= pair_v;
        end
    end

    always_ff @(posedge clk_cn or negedge rst_n) begin
        if (!rst_n) begin
            q_cn <= '0;
            v_cn <= 1'b0;
        end else begin
            q_cn <= late_w;
            v_cn <= v_c;
        end
    end

    assign q       = clk_c ? q_c : q_cn;
    assign q_valid = clk_c ? v_c : v_cn;

    // R2: a fresh line always yields a second pair on the next cycle
    p_second_pair_r2: assert property (@(posedge clk_k) disable iff (!rst_n)
        $rose(pair_v) |=> pair_v);
    // R5: a new fetch never lands while the upper pair is pending
    p_fetch_when_idle_r5: assert property (@(posedge clk_k) disable iff (!rst_n)
        fetch_v |-> st == OUT_IDLE);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk_k,
    input  logic              clk_kn,
    input  logic              clk_c,
    input  logic              clk_cn,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rps_n,
    input  logic              wps_n,
    input  logic [LANES-1:0]  bws_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q,
    output logic              q_valid
);
    localparam int LINE_W = BURST * WORD_W;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LINE_W-1:0] wr_data;
    logic [BURST*LANES-1:0] wr_sel_n;
    logic              fetch_v;
    logic [ADDR_W-1:0] fetch_addr;
    logic [LINE_W-1:0] rd_line;

    qdr_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_wr (
        .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n), .addr(addr),
        .wps_n(wps_n), .bws_n(bws_n), .d(d), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_sel_n(wr_sel_n)
    );

    qdr_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk_k(clk_k), .rst_n(rst_n), .addr(addr), .rps_n(rps_n),
        .fetch_v(fetch_v), .fetch_addr(fetch_addr)
    );

    qdr_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_mem (
        .clk_k(clk_k), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_sel_n(wr_sel_n), .rd_addr(fetch_addr), .rd_line(rd_line)
    );

    qdr_out_ddr #(.WORD_W(WORD_W)) u_out (
        .clk_k(clk_k), .clk_c(clk_c), .clk_cn(clk_cn), .rst_n(rst_n),
        .fetch_v(fetch_v), .line(rd_line), .q(q), .q_valid(q_valid)
    );
endmodule

// File: tb/sim_qdr_burst_sram.sv
`timescale 1ns/1ps
module sim_qdr_burst_sram;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NCYC   = 1024;
    localparam int NSLOT  = 2 * NCYC;
    localparam int P1     = 2 * DEPTH;
    localparam int P2     = 4 * DEPTH;
    localparam int TAIL   = 12;

    logic clk_k = 1'b0;
    logic clk_kn, clk_c, clk_cn;
    logic rst_n;
    logic [ADDR_W-1:0] addr;
    logic rps_n, wps_n;
    logic [1:0] bws_n;
    logic [17:0] d;
    logic [17:0] q;
    logic q_valid;

    always #4 clk_k = ~clk_k;
    assign clk_kn = ~clk_k;
    assign clk_c  = clk_k;
    assign clk_cn = clk_kn;

    qdr_burst_sram #(.ADDR_W(ADDR_W)) u0 (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .rst_n(rst_n), .addr(addr), .rps_n(rps_n), .wps_n(wps_n),
        .bws_n(bws_n), .d(d), .q(q), .q_valid(q_valid)
    );

    bit               s_sel  [NSLOT];
    logic [ADDR_W-1:0] s_addr [NSLOT];
    logic [17:0]      s_d    [NSLOT];
    logic [1:0]       s_bws  [NSLOT];
    bit               wacc   [NCYC];
    bit               exp_v  [NSLOT+12];
    logic [17:0]      exp_q  [NSLOT+12];
    int               exp_tag[NSLOT+12];
    bit               ign_v  [NSLOT+12];
    logic [71:0]      refmem [DEPTH];
    bit               f_ign  [DEPTH];
    bit               f_part [DEPTH];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic drive(int s);
        addr  = s_addr[s];
        d     = s_d[s];
        bws_n = s_bws[s];
        if (s % 2 == 0) begin rps_n = s_sel[s]; wps_n = 1'b1; end
        else            begin wps_n = s_sel[s]; rps_n = 1'b1; end
    endtask

    task automatic check_slot(int s);
        int vt;
        if (exp_v[s]) vt = 2;
        else if (s < 8) vt = 1;
        else if (ign_v[s]) vt = 5;
        else vt = 7;
        checks++;
        if (q_valid !== exp_v[s]) begin
            errors++;
            $display("FAIL %s slot %0d q_valid got %b exp %b", tag_name(vt), s, q_valid, exp_v[s]);
        end
        if (exp_v[s]) begin
            checks++;
            if (q !== exp_q[s]) begin
                errors++;
                $display("FAIL %s slot %0d q got %h exp %h", tag_name(exp_tag[s]), s, q, exp_q[s]);
            end
        end
    endtask

    task automatic build_stimulus();
        for (int s = 0; s < NSLOT; s++) begin
            s_sel[s]  = 1'b1;
            s_addr[s] = '0;
            s_d[s]    = 18'($urandom);
            s_bws[s]  = 2'b00;
        end
        for (int i = 0; i < NCYC; i++) begin
            if (i < P1) begin
                // R6 sweep: write line and read it in the same cycle pair
                if (i % 2 == 0) begin
                    s_sel[2*i] = 1'b0;   s_addr[2*i]   = ADDR_W'(i / 2);
                    s_sel[2*i+1] = 1'b0; s_addr[2*i+1] = ADDR_W'(i / 2);
                end else begin
                    // R5: refused requests on both ports
                    s_sel[2*i] = 1'b0;   s_addr[2*i] = ADDR_W'(i / 2 + 7);
                    if (i > 1) begin
                        s_sel[2*i+1] = 1'b0; s_addr[2*i+1] = ADDR_W'(i / 2 - 1);
                    end
                end
            end else if (i < P2) begin
                s_sel[2*i]  = 1'b0;
                s_addr[2*i] = ADDR_W'((i - P1) / 2);
            end else if (i < NCYC - TAIL) begin
                s_sel[2*i]    = ($urandom % 4) == 0;
                s_addr[2*i]   = ADDR_W'($urandom % 8);
                s_sel[2*i+1]  = ($urandom % 4) == 0;
                s_addr[2*i+1] = ADDR_W'($urandom % 8);
                s_bws[2*i]    = 2'($urandom);
                s_bws[2*i+1]  = 2'($urandom);
            end
        end
    endtask

    task automatic build_model();
        bit rprev;
        for (int s = 0; s < NSLOT + 12; s++) begin
            exp_v[s] = 1'b0; exp_q[s] = '0; exp_tag[s] = 7; ign_v[s] = 1'b0;
        end
        for (int a = 0; a < DEPTH; a++) begin
            refmem[a] = '0; f_ign[a] = 1'b0; f_part[a] = 1'b0;
        end
        for (int i = 0; i < NCYC; i++)
            wacc[i] = !s_sel[2*i+1] && !(i > 0 && wacc[i-1]) && (2*i+3 < NSLOT);
        rprev = 1'b0;
        for (int i = 0; i < NCYC; i++) begin
            bit racc;
            if (wacc[i]) begin
                int wa;
                bit part;
                wa = int'(s_addr[2*i+1]);
                part = 1'b0;
                for (int b = 0; b < 4; b++) begin
                    for (int l = 0; l < 2; l++) begin
                        if (!s_bws[2*i+b][l])
                            refmem[wa][b*18 + l*9 +: 9] = s_d[2*i+b][l*9 +: 9];
                        else
                            part = 1'b1;
                    end
                end
                f_part[wa] = part;
                f_ign[wa]  = 1'b0;
            end else if (!s_sel[2*i+1]) begin
                f_ign[s_addr[2*i+1]] = 1'b1;
            end
            racc = !s_sel[2*i] && !rprev;
            if (racc) begin
                int ra;
                int t;
                ra = int'(s_addr[2*i]);
                if ((wacc[i] && int'(s_addr[2*i+1]) == ra) ||
                    (i + 1 < NCYC && wacc[i+1] && int'(s_addr[2*i+3]) == ra)) t = 6;
                else if (f_ign[ra])  t = 5;
                else if (f_part[ra]) t = 4;
                else                 t = 3;
                for (int b = 0; b < 4; b++) begin
                    exp_v[2*i+8+b]   = 1'b1;
                    exp_q[2*i+8+b]   = refmem[ra][b*18 +: 18];
                    exp_tag[2*i+8+b] = t;
                end
            end else if (!s_sel[2*i]) begin
                for (int b = 0; b < 4; b++) ign_v[2*i+8+b] = 1'b1;
            end
            rprev = racc;
        end
    endtask

    initial begin
        rst_n = 1'b0; rps_n = 1'b1; wps_n = 1'b1;
        addr = '0; d = '0; bws_n = 2'b11;
        build_stimulus();
        build_model();
        repeat (4) begin
            @(posedge clk_k); #1;
            checks++;  // R1: quiet during reset
            if (q_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 in reset q_valid got %b exp 0", q_valid);
            end
        end
        rst_n = 1'b1;
        drive(0);
        for (int s = 0; s < NSLOT; s++) begin
            if (s % 2 == 0) @(posedge clk_k);
            else            @(posedge clk_kn);
            #1;
            check_slot(s);
            if (s + 1 < NSLOT) drive(s + 1);
            else begin rps_n = 1'b1; wps_n = 1'b1; end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule